// File: doc/BRIEF.md
# Correctable Fill Error Logger

This block watches the data returned by a second-level cache fill and reacts to single-bit correctable ECC errors found in the 128-bit subblock being filled. Each subblock is two 64-bit quadwords. The ECC checker in front of the block supplies an error strobe and one 8-bit syndrome per quadword, where a zero syndrome means that quadword is clean. Each error also comes with the cache line address and a tag that says how the data was being used. The data may satisfy a demand load, or it may be a fill that no load consumes. It may also be a speculative load, a victim read-out, or a lookup that missed in both cache levels.

Depending on that tag, the block does three things. It may capture the error into sticky status, address and syndrome registers for software to read. It may request a hardware scrub from the cache controller: the line is evicted to the victim buffer and then written back to the first-level cache, after which the stalled load may be retried. It may also raise a corrected-read-data interrupt pulse, which software gates with an enable input. The captured values stay frozen until software clears the status bits with a write-one-to-clear strobe.

Top module: `fill_ecc_logger`

## Requirements
- R1: After reset, both status bits, the captured line address, both captured syndromes, the interrupt, the scrub request and the retry pulse are all zero.
- R2: An error counts only when `err_vld` is 1 and at least one of `syn_q0`/`syn_q1` is nonzero. An error strobe with both syndromes zero changes no output.
- R3: A counted error with `acc_type` 0 (demand load) sets `stat[0]` (fill error) and `stat[1]` (load error) on the next cycle. It also captures `fill_line` into `log_line` and the two syndromes into `log_syn0`/`log_syn1`.
- R4: A counted error with `acc_type` 1 (fill not consumed) sets only `stat[0]`, captures line and syndromes, and starts no scrub.
- R5: A counted error with `acc_type` 2 (speculative load), 3 (victim read) or 4 (double miss) changes neither the status nor the captured values and starts no scrub. Values 5 to 7 are ignored completely.
- R6: `crd_irq` is a one-cycle pulse in the cycle after a counted error with `acc_type` 0 to 4, given that `irq_en` was 1 in the error cycle. It never rises when `irq_en` was 0.
- R7: While either status bit is set, `log_line`, `log_syn0`, `log_syn1` and `stat` gain nothing from new errors. Only the interrupt still fires for them.
- R8: When `clr_vld` is 1, every status bit that has a 1 in `clr_bits` is cleared on the next cycle. Captured values remain readable, and the next logged error replaces them.
- R9: A counted demand-load error while no scrub is outstanding raises `scrub_vld` on the next cycle, with `scrub_line` equal to that error's `fill_line`. Both are held until a cycle in which `scrub_rdy` is 1.
- R10: From the scrub request until `scrub_done`, further demand-load errors start no new scrub and leave `scrub_line` unchanged.
- R11: A `scrub_done` pulse after the request was accepted gives a one-cycle `retry_ld` pulse on the next cycle and ends the outstanding scrub. `scrub_done` at any other time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_vld | input | 1 | Error report strobe from the ECC checker |
| acc_type | input | 3 | Access kind: 0 load, 1 fill, 2 speculative, 3 victim, 4 double miss |
| fill_line | input | 37 | Line address of the fill (address bits 42 to 6) |
| syn_q0 | input | 8 | Syndrome of quadword 0 of the subblock |
| syn_q1 | input | 8 | Syndrome of quadword 1 of the subblock |
| irq_en | input | 1 | Interrupt enable |
| clr_vld | input | 1 | Status clear strobe |
| clr_bits | input | 2 | Write-one-to-clear mask for `stat` |
| scrub_rdy | input | 1 | Cache controller accepts the scrub request |
| scrub_done | input | 1 | Eviction and write-back finished |
| stat | output | 2 | Bit 0 fill error, bit 1 load error |
| log_line | output | 37 | Captured line address |
| log_syn0 | output | 8 | Captured syndrome of quadword 0 |
| log_syn1 | output | 8 | Captured syndrome of quadword 1 |
| crd_irq | output | 1 | Corrected-read-data interrupt pulse |
| scrub_vld | output | 1 | Scrub request valid |
| scrub_line | output | 37 | Line to scrub |
| retry_ld | output | 1 | Load may be retried |

## Verification
Suppose the freeze flag or the access-type decode went wrong. The first error after that would show a changed `log_line` or syndrome one cycle after the strobe, while `stat` was still set, or a status bit set for a speculative or victim access. A scrub controller stuck in the wrong state shows within one cycle. The symptom is a `scrub_vld` that drops without `scrub_rdy`, a second request before `scrub_done`, or a `retry_ld` that is missing or lasts two cycles. The bench compares every output each cycle against its own model, so any divergence is reported in the cycle it appears.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  typedef enum logic [2:0] {
    ACC_LOAD  = 3'd0,
    ACC_FILL  = 3'd1,
    ACC_SPEC  = 3'd2,
    ACC_VICT  = 3'd3,
    ACC_DMISS = 3'd4
  } acc_e;

  typedef struct packed {
    logic irq;
    logic log;
    logic ld;
    logic scrub;
  } act_t;

  typedef enum logic [1:0] {
    SC_IDLE = 2'd0,
    SC_REQ  = 2'd1,
    SC_WAIT = 2'd2
  } scrub_st_e;
endpackage

// File: rtl/ecc_class_decode.sv
module ecc_class_decode
  import ecc_log_pkg::*;
#(
  parameter int SYN_W = 8,
  parameter int NQ    = 2
) (
  input  logic                err_vld,
  input  logic [2:0]          acc_type,
  input  logic [NQ*SYN_W-1:0] syn_all,
  output act_t                act
);
  logic [NQ-1:0] qerr;
  logic          hit;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign qerr[q] = |syn_all[q*SYN_W +: SYN_W];
  end

  assign hit = err_vld && (|qerr);

  always_comb begin
    act = '0;
    if (hit) begin
      unique case (acc_type)
        ACC_LOAD:  begin act.irq = 1'b1; act.log = 1'b1; act.ld = 1'b1; act.scrub = 1'b1; end
        ACC_FILL:  begin act.irq = 1'b1; act.log = 1'b1; end
        ACC_SPEC,
        ACC_VICT,
        ACC_DMISS: act.irq = 1'b1;
        default:   act = '0;
      endcase
    end
  end
endmodule

// File: rtl/ecc_log_regs.sv
module ecc_log_regs #(
  parameter int LA_W  = 37,
  parameter int SYN_W = 8,
  parameter int NQ    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                log_ev,
  input  logic                ld_ev,
  input  logic [LA_W-1:0]     line_in,
  input  logic [NQ*SYN_W-1:0] syn_in,
  input  logic                clr_vld,
  input  logic [1:0]          clr_bits,
  output logic [1:0]          stat,
  output logic [LA_W-1:0]     line_q,
  output logic [NQ*SYN_W-1:0] syn_q
);
  logic       capture;
  logic [1:0] set_m;
  logic [1:0] clr_m;

  assign capture = (stat == 2'b00) && log_ev;
  assign set_m   = capture ? {ld_ev, 1'b1} : 2'b00;
  assign clr_m   = clr_vld ? clr_bits : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat   <= '0;
      line_q <= '0;
    end else begin
      stat <= (stat & ~clr_m) | set_m;
      if (capture) line_q <= line_in;
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_syn
    always_ff @(posedge clk) begin
      if (rst)          syn_q[q*SYN_W +: SYN_W] <= '0;
      else if (capture) syn_q[q*SYN_W +: SYN_W] <= syn_in[q*SYN_W +: SYN_W];
    end
  end

  // R7
  log_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (stat != 2'b00) |=> ($stable(line_q) && $stable(syn_q)));
endmodule

// File: rtl/ecc_scrub_ctl.sv
module ecc_scrub_ctl
  import ecc_log_pkg::*;
#(
  parameter int LA_W = 37
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [LA_W-1:0] line_in,
  input  logic            rdy,
  input  logic            done,
  output logic            vld,
  output logic [LA_W-1:0] line_q,
  output logic            retry
);
  scrub_st_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SC_IDLE;
      line_q <= '0;
      retry  <= 1'b0;
    end else begin
      retry <= 1'b0;
      unique case (st)
        SC_IDLE: if (start) begin st <= SC_REQ; line_q <= line_in; end
        SC_REQ:  if (rdy) st <= SC_WAIT;
        SC_WAIT: if (done) begin st <= SC_IDLE; retry <= 1'b1; end
        default: st <= SC_IDLE;
      endcase
    end
  end

  assign vld = (st == SC_REQ);

  // R9
  scrub_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (vld && !rdy) |=> (vld && $stable(line_q)));
  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (st != SC_IDLE) |=> $stable(line_q));
  // R11
  retry_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    retry |=> !retry);
endmodule

// File: rtl/fill_ecc_logger.sv
module fill_ecc_logger
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W   = 43,
  parameter int LINE_LSB = 6,
  parameter int SYN_W    = 8,
  localparam int LA_W    = ADDR_W - LINE_LSB,
  localparam int NQ      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             err_vld,
  input  logic [2:0]       acc_type,
  input  logic [LA_W-1:0]  fill_line,
  input  logic [SYN_W-1:0] syn_q0,
  input  logic [SYN_W-1:0] syn_q1,
  input  logic             irq_en,
  input  logic             clr_vld,
  input  logic [1:0]       clr_bits,
  input  logic             scrub_rdy,
  input  logic             scrub_done,
  output logic [1:0]       stat,
  output logic [LA_W-1:0]  log_line,
  output logic [SYN_W-1:0] log_syn0,
  output logic [SYN_W-1:0] log_syn1,
  output logic             crd_irq,
  output logic             scrub_vld,
  output logic [LA_W-1:0]  scrub_line,
  output logic             retry_ld
);
  act_t                act;
  logic [NQ*SYN_W-1:0] syn_all;
  logic [NQ*SYN_W-1:0] syn_log;

  assign syn_all = {syn_q1, syn_q0};

  ecc_class_decode #(.SYN_W(SYN_W), .NQ(NQ)) u_dec (
    .err_vld (err_vld),
    .acc_type(acc_type),
    .syn_all (syn_all),
    .act     (act)
  );

  ecc_log_regs #(.LA_W(LA_W), .SYN_W(SYN_W), .NQ(NQ)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .log_ev  (act.log),
    .ld_ev   (act.ld),
    .line_in (fill_line),
    .syn_in  (syn_all),
    .clr_vld (clr_vld),
    .clr_bits(clr_bits),
    .stat    (stat),
    .line_q  (log_line),
    .syn_q   (syn_log)
  );

  assign log_syn0 = syn_log[SYN_W-1:0];
  assign log_syn1 = syn_log[NQ*SYN_W-1:SYN_W];

  ecc_scrub_ctl #(.LA_W(LA_W)) u_scrub (
    .clk    (clk),
    .rst    (rst),
    .start  (act.scrub),
    .line_in(fill_line),
    .rdy    (scrub_rdy),
    .done   (scrub_done),
    .vld    (scrub_vld),
    .line_q (scrub_line),
    .retry  (retry_ld)
  );

  always_ff @(posedge clk) begin
    if (rst) crd_irq <= 1'b0;
    else     crd_irq <= act.irq && irq_en;
  end

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !crd_irq);
endmodule

// File: tb/sim_fill_ecc_logger.sv
module sim_fill_ecc_logger;
  localparam int LA_W = 37;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            err_vld = 1'b0;
  logic [2:0]      acc_type = '0;
  logic [LA_W-1:0] fill_line = '0;
  logic [7:0]      syn_q0 = '0, syn_q1 = '0;
  logic            irq_en = 1'b0, clr_vld = 1'b0;
  logic [1:0]      clr_bits = '0;
  logic            scrub_rdy = 1'b0, scrub_done = 1'b0;
  logic [1:0]      stat;
  logic [LA_W-1:0] log_line, scrub_line;
  logic [7:0]      log_syn0, log_syn1;
  logic            crd_irq, scrub_vld, retry_ld;

  int total = 0;
  int bad   = 0;

  // expected state
  logic [1:0]      m_stat = '0;
  logic [LA_W-1:0] m_line = '0, m_sline = '0;
  logic [7:0]      m_s0 = '0, m_s1 = '0;
  logic            m_irq = 1'b0, m_retry = 1'b0;
  int              m_sst = 0;

  always #2.5 clk = ~clk;

  fill_ecc_logger u0 (.*);

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "stat", 64'(stat), 64'(m_stat));
    chk(tag, "log_line", 64'(log_line), 64'(m_line));
    chk(tag, "log_syn0", 64'(log_syn0), 64'(m_s0));
    chk(tag, "log_syn1", 64'(log_syn1), 64'(m_s1));
    chk(tag, "crd_irq", 64'(crd_irq), 64'(m_irq));
    chk(tag, "scrub_vld", 64'(scrub_vld), 64'(m_sst == 1));
    chk(tag, "scrub_line", 64'(scrub_line), 64'(m_sline));
    chk(tag, "retry_ld", 64'(retry_ld), 64'(m_retry));
  endtask

  function automatic logic counted(input logic ev, input logic [7:0] a, input logic [7:0] b);
    return ev && (a != 0 || b != 0);
  endfunction

  task automatic model(input logic ev, input logic [2:0] ty, input logic [LA_W-1:0] ln,
                       input logic [7:0] a, input logic [7:0] b, input logic en,
                       input logic cv, input logic [1:0] cb, input logic rd, input logic dn);
    logic       tr  = counted(ev, a, b);
    logic       lg  = tr && (ty == 3'd0 || ty == 3'd1);
    logic       cap = lg && (m_stat == 2'b00);
    logic [1:0] nst = (m_stat & ~(cv ? cb : 2'b00)) | (cap ? {ty == 3'd0, 1'b1} : 2'b00);
    if (cap) begin m_line = ln; m_s0 = a; m_s1 = b; end
    m_stat  = nst;
    m_irq   = tr && (ty <= 3'd4) && en;
    m_retry = (m_sst == 2) && dn;
    case (m_sst)
      0: if (tr && ty == 3'd0) begin m_sst = 1; m_sline = ln; end
      1: if (rd) m_sst = 2;
      default: if (dn) m_sst = 0;
    endcase
  endtask

  task automatic cyc(input logic ev, input logic [2:0] ty, input logic [LA_W-1:0] ln,
                     input logic [7:0] a, input logic [7:0] b, input logic en,
                     input logic cv, input logic [1:0] cb, input logic rd, input logic dn,
                     input string tag);
    err_vld = ev; acc_type = ty; fill_line = ln; syn_q0 = a; syn_q1 = b; irq_en = en;
    clr_vld = cv; clr_bits = cb; scrub_rdy = rd; scrub_done = dn;
    @(posedge clk);
    model(ev, ty, ln, a, b, en, cv, cb, rd, dn);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 3'd0, '0, 8'h0, 8'h0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_all("R1");
    // zero syndromes
    cyc(1'b1, 3'd0, 37'h1_2345_6789, 8'h0, 8'h0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, "R2");
    // demand load error
    cyc(1'b1, 3'd0, 37'h0_0abc_def0, 8'h00, 8'h5a, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, "R3");
    // scrub held without ready, new load error must not restart
    cyc(1'b1, 3'd0, 37'h1_ffff_0000, 8'h33, 8'h00, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, "R7");
    idle("R9");
    cyc(1'b0, 3'd0, '0, 8'h0, 8'h0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, "R9");
    cyc(1'b1, 3'd0, 37'h0_1111_2222, 8'h01, 8'h01, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, "R10");
    cyc(1'b0, 3'd0, '0, 8'h0, 8'h0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, "R11");
    idle("R11");
    // done while idle ignored
    cyc(1'b0, 3'd0, '0, 8'h0, 8'h0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, "R11");
    // clear bit 1 only, then bit 0
    cyc(1'b0, 3'd0, '0, 8'h0, 8'h0, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0, "R8");
    cyc(1'b0, 3'd0, '0, 8'h0, 8'h0, 1'b1, 1'b1, 2'b01, 1'b0, 1'b0, "R8");
    // unconsumed fill
    cyc(1'b1, 3'd1, 37'h0_7777_8888, 8'h90, 8'h00, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, "R4");
    cyc(1'b0, 3'd0, '0, 8'h0, 8'h0, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0, "R8");
    // signal-only classes and reserved codes
    for (int t = 2; t < 8; t++)
      cyc(1'b1, 3'(t), 37'h1_0000_0001 + 37'(t), 8'h44, 8'h22, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, "R5");
    // interrupt disabled
    cyc(1'b1, 3'd3, 37'h0_0000_0042, 8'h01, 8'h00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, "R6");
    cyc(1'b1, 3'd1, 37'h0_0000_0043, 8'h01, 8'h00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, "R6");
    cyc(1'b0, 3'd0, '0, 8'h0, 8'h0, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0, "R8");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic ev = ($urandom % 3) == 0;
      logic [2:0] ty = 3'($urandom % 8);
      logic [7:0] a = ($urandom % 2) ? 8'($urandom) : 8'h00;
      logic [7:0] b = ($urandom % 2) ? 8'($urandom) : 8'h00;
      logic [LA_W-1:0] ln = {5'($urandom), 32'($urandom)};
      logic cv = ($urandom % 10) == 0;
      cyc(ev, ty, ln, a, b, 1'($urandom), cv, 2'($urandom), 1'($urandom), ($urandom % 4) == 0, "R7");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule